// File: doc/BRIEF.md
# Latched 64-bit Match Timer

This block is a memory-mapped system timer. A prescaler divides the input clock and advances a free-running 64-bit counter. Software reads the counter coherently by issuing a latch command, which freezes a copy of both 32-bit halves in one cycle. The halves can then be read one after the other without tearing. Both live counter words can be written, so software can preset the count or restore it after a power transition.

Six 32-bit compare channels watch the low counter word. When a counter tick makes the low word equal to a channel's value, that channel's sticky status flag is set. A per-channel enable routes the flags onto a level interrupt line. Channel 5 can also be armed as a watchdog that drives a reset request. Access is through a plain 32-bit register bus with a write strobe, a read strobe, a byte address, write data and registered read data.

Top module: `match_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` and `wdog_rst` are low. A read of any address outside the map returns zero. `rdata` is registered and is valid in the cycle after `rd_en`. Map: 0x00 count low, 0x04 count high, 0x08+4n compare n (n = 0..5), 0x20 status, 0x24 interrupt enable, 0x28 watchdog arm, 0x2C divider, 0x30 latch, 0x34 snapshot low, 0x38 snapshot high.
- R2: A write with bit 0 set to 0x30 copies the whole 64-bit count into the snapshot in one cycle. Later changes to the live count do not alter the snapshot. A write to 0x30 with bit 0 clear leaves the snapshot untouched.
- R3: Writes to 0x00 and 0x04 replace the live low and high words, and a written word takes priority over a tick in the same cycle. The count is 64 bits wide, so a tick carries from the low word into the high word.
- R4: With divider value D, the counter advances once every 2*(D+1) clock cycles. A write to the divider restarts the prescale phase, so the first tick after a divider write lands 2*(D+1) cycles after that write.
- R5: When a tick makes the low word equal to compare register n, status bit n is set.
- R6: Status bits clear on a write of 1 to that bit at 0x20. Bits written 0 keep their value.
- R7: `irq` is high exactly when some status bit n and interrupt-enable bit n are both set. It follows with one cycle of register delay.
- R8: When bit 0 of 0x28 is set and status bit 5 is set, `wdog_rst` goes high one cycle later. It falls once either condition is gone. With bit 0 clear, a channel-5 hit sets the flag but leaves `wdog_rst` low.
- R9: A flag is set only on a tick. Writing the counter to a compare value sets nothing, and a flag cleared while the count rests on the matching value between ticks stays clear.
- R10: If a status clear and a new hit on the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, OR of enabled flags |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
The hardest situation to create is R10: a software clear landing on the very clock edge where a tick produces a hit on the same channel. From the ports, the tick phase is normally unknown. The bench relies on the R4 phase restart. It writes a large divider, presets the count one below the compare value, and then counts edges so that the clear write meets the tick exactly 2*(D+1) cycles after the divider write. It reuses the same phase restart to place latch commands on known edges. That makes the exact rate check and the first-tick check possible.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 64;
  localparam int NUM_CH = 6;
  localparam int WDOG_CH = NUM_CH - 1;

  // word indices (byte address / 4)
  localparam int IDX_CNT_LO  = 0;
  localparam int IDX_CNT_HI  = 1;
  localparam int IDX_MATCH0  = 2;
  localparam int IDX_STATUS  = IDX_MATCH0 + NUM_CH;
  localparam int IDX_IEN     = IDX_STATUS + 1;
  localparam int IDX_WDEN    = IDX_STATUS + 2;
  localparam int IDX_DIV     = IDX_STATUS + 3;
  localparam int IDX_LATCH   = IDX_STATUS + 4;
  localparam int IDX_SNAP_LO = IDX_STATUS + 5;
  localparam int IDX_SNAP_HI = IDX_STATUS + 6;
endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             restart,
  output logic             tick
);
  localparam int PS_W = DIV_W + 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] limit;

  // period 2*(div+1) -> terminal count 2*div+1
  assign limit = {div_val, 1'b1};
  assign tick  = !restart && (ps_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) ps_q <= '0;
    else                        ps_q <= ps_q + 1'b1;
  end

  // R4: the shortest period is two cycles
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              latch,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  snap
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = tick ? count + CNT_W'(1) : count;
    if (wr_lo) count_d[WORD_W-1:0] = wdata;
    if (wr_hi) count_d[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      snap  <= '0;
    end else begin
      count <= count_d;
      if (latch) snap <= count;
    end
  end

  // R3: an unwritten tick advances the full 64-bit count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !wr_hi) |=> (count == $past(count) + CNT_W'(1)));
  // R2: snapshot only changes on a latch command
  a_r2_snap_stable: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(snap));
endmodule

// File: rtl/mtimer_match_bank.sv
module mtimer_match_bank #(
  parameter int N = 6,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        wr_sel,
  input  logic [W-1:0]        wdata,
  input  logic                adv,
  input  logic [W-1:0]        next_lo,
  input  logic [N-1:0]        clr,
  output logic [N-1:0][W-1:0] match_q,
  output logic [N-1:0]        status
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic hit;
    assign hit = adv && (next_lo == match_q[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        match_q[g] <= '0;
        status[g]  <= 1'b0;
      end else begin
        if (wr_sel[g]) match_q[g] <= wdata;
        status[g] <= hit | (status[g] & ~clr[g]);
      end
    end

    // R5 and R10: a hit always leaves the flag set
    a_r5_hit_sets: assert property (@(posedge clk) disable iff (rst)
      hit |=> status[g]);
    // R6: without a clear the flag is sticky
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
      (status[g] && !clr[g]) |=> status[g]);
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              wdog_rst
);
  import mtimer_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  int               idx_i;
  logic             aligned;
  logic             wr_ok;

  assign idx     = addr[ADDR_W-1:2];
  assign idx_i   = int'(idx);
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && aligned;

  // control registers
  logic [NUM_CH-1:0] ien_q;
  logic              wden_q;
  logic [DIV_W-1:0]  div_q;
  logic              div_wr;

  assign div_wr = wr_ok && (idx_i == IDX_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      wden_q <= 1'b0;
      div_q  <= '0;
    end else if (wr_ok) begin
      if (idx_i == IDX_IEN)  ien_q  <= wdata[NUM_CH-1:0];
      if (idx_i == IDX_WDEN) wden_q <= wdata[0];
      if (div_wr)            div_q  <= wdata[DIV_W-1:0];
    end
  end

  // prescaler
  logic tick;
  mtimer_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .div_val(div_q), .restart(div_wr), .tick(tick)
  );

  // counter and snapshot
  logic             wr_lo, wr_hi, latch_cmd;
  logic [CNT_W-1:0] count, snap;

  assign wr_lo     = wr_ok && (idx_i == IDX_CNT_LO);
  assign wr_hi     = wr_ok && (idx_i == IDX_CNT_HI);
  assign latch_cmd = wr_ok && (idx_i == IDX_LATCH) && wdata[0];

  mtimer_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(wdata), .latch(latch_cmd), .count(count), .snap(snap)
  );

  // compare channels
  logic [NUM_CH-1:0]             m_sel;
  logic [NUM_CH-1:0]             st_clr;
  logic [NUM_CH-1:0][WORD_W-1:0] match_q;
  logic [NUM_CH-1:0]             status;
  logic [WORD_W-1:0]             next_lo;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign m_sel[g] = wr_ok && (idx_i == IDX_MATCH0 + g);
  end

  assign st_clr  = (wr_ok && idx_i == IDX_STATUS) ? wdata[NUM_CH-1:0] : '0;
  assign next_lo = count[WORD_W-1:0] + WORD_W'(1);

  mtimer_match_bank #(.N(NUM_CH), .W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .wr_sel(m_sel), .wdata(wdata),
    .adv(tick && !wr_lo), .next_lo(next_lo), .clr(st_clr),
    .match_q(match_q), .status(status)
  );

  // read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int i = 0; i < NUM_CH; i++)
        if (idx_i == IDX_MATCH0 + i) rd_mux = match_q[i];
      case (idx_i)
        IDX_CNT_LO:  rd_mux = count[WORD_W-1:0];
        IDX_CNT_HI:  rd_mux = count[CNT_W-1:WORD_W];
        IDX_STATUS:  rd_mux = 32'(status);
        IDX_IEN:     rd_mux = 32'(ien_q);
        IDX_WDEN:    rd_mux = 32'(wden_q);
        IDX_DIV:     rd_mux = 32'(div_q);
        IDX_SNAP_LO: rd_mux = snap[WORD_W-1:0];
        IDX_SNAP_HI: rd_mux = snap[CNT_W-1:WORD_W];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      irq      <= 1'b0;
      wdog_rst <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq      <= |(status & ien_q);
      wdog_rst <= wden_q && status[WDOG_CH];
    end
  end

  // R8: a reset request needs the channel-5 flag and the arm bit
  a_r8_wdog_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst) |-> ($past(status[WDOG_CH]) && $past(wden_q)));
  // R7: no interrupt without an enabled flag in the cycle before
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(status & ien_q) != '0));
endmodule

// File: tb/test_match_timer.sv
module test_match_timer;
  localparam logic [7:0] A_CLO = 8'h00, A_CHI = 8'h04, A_ST = 8'h20,
                         A_IE = 8'h24, A_WD = 8'h28, A_DV = 8'h2C,
                         A_LT = 8'h30, A_SLO = 8'h34, A_SHI = 8'h38;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, raw = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdog_rst;

  match_timer i_match_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  int checks = 0, errors = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sbq[$];

  function automatic logic [7:0] a_m(int n);
    return 8'(8'h08 + 4 * n);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    sbq.push_back('{e, tag});
    rd_en = 1'b1; raw = 1'b0; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_raw(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; raw = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; raw = 1'b0;
    v = rdata;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  // monitor: compare scoreboard reads one cycle after the strobe
  logic mon_q = 1'b0;
  always @(posedge clk) mon_q <= rd_en && !raw;
  always @(negedge clk) begin
    if (mon_q) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", rdata);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        chk(rdata, it.exp, it.tag);
      end
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(32'(irq), 0, "R1 irq after reset");
    chk(32'(wdog_rst), 0, "R1 wdog after reset");
    rd_exp(A_DV, 0, "R1 divider reset");
    rd_exp(A_ST, 0, "R1 status reset");
    rd_exp(A_SHI, 0, "R1 snapshot reset");
    rd_exp(a_m(3), 0, "R1 compare reset");
    rd_exp(8'h3C, 0, "R1 unmapped read");
    rd_exp(8'hC0, 0, "R1 unmapped high read");

    // R2 / R3 snapshot coherence and counter preset
    wr(A_DV, 1000);
    wr(A_CLO, 32'h89AB_CDEF);
    wr(A_CHI, 32'h0123_4567);
    wr(A_LT, 1);
    wr(A_CLO, 5);
    rd_exp(A_SLO, 32'h89AB_CDEF, "R2 snapshot low");
    rd_exp(A_SHI, 32'h0123_4567, "R2 snapshot high");
    rd_exp(A_CLO, 5, "R3 live low written");
    rd_exp(A_CHI, 32'h0123_4567, "R3 live high written");
    wr(A_LT, 0);
    rd_exp(A_SLO, 32'h89AB_CDEF, "R2 latch with bit0 clear");

    // R3 carry, R5 wrap hits every zero compare
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CHI, 7);
    wr(A_ST, 32'h3F);
    wr(A_DV, 0);
    repeat (10) @(negedge clk);
    wr(A_LT, 1);
    rd_exp(A_SHI, 8, "R3 carry into high word");
    rd_exp(A_ST, 32'h3F, "R5 wrap hits all channels");

    // R4 exact rate: latches 80 edges apart with period 8
    wr(A_DV, 3);
    wr(A_LT, 1);
    rd_raw(A_SLO, v1);
    repeat (78) @(negedge clk);
    wr(A_LT, 1);
    rd_exp(A_SLO, v1 + 10, "R4 ten ticks in 80 cycles");

    // R4 first tick 2*(D+1) after divider write
    wr(A_DV, 1000);
    wr(A_CLO, 0);
    wr(A_DV, 2);
    repeat (5) @(negedge clk);
    wr(A_LT, 1);
    rd_exp(A_SLO, 0, "R4 no tick before restart period");
    wr(A_LT, 1);
    rd_exp(A_SLO, 1, "R4 first tick after restart");

    // R9 / R5 / R6 / R7
    wr(A_DV, 1000);
    wr(A_ST, 32'h3F);
    wr(A_CLO, 200);
    wr(a_m(0), 200);
    wr(a_m(1), 201);
    wr(A_IE, 1);
    rd_exp(A_ST, 0, "R9 counter write does not hit");
    repeat (2100) @(negedge clk);
    rd_exp(A_ST, 2, "R5 channel 1 hit on tick");
    chk(32'(irq), 0, "R7 disabled channel gives no irq");
    wr(A_IE, 2);
    repeat (3) @(negedge clk);
    chk(32'(irq), 1, "R7 enabled flag raises irq");
    wr(A_ST, 0);
    rd_exp(A_ST, 2, "R6 write zero keeps flag");
    wr(A_ST, 2);
    repeat (3) @(negedge clk);
    chk(32'(irq), 0, "R7 irq drops after clear");
    rd_exp(A_ST, 0, "R6 write one clears flag");
    repeat (200) @(negedge clk);
    rd_exp(A_ST, 0, "R9 no re-detect while holding");

    // R10 clear and hit on the same edge
    wr(A_DV, 1000);
    wr(A_CLO, 499);
    wr(a_m(2), 500);
    wr(A_ST, 32'h3F);
    repeat (1998) @(negedge clk);
    wr(A_ST, 4);
    rd_exp(A_ST, 4, "R10 hit wins over clear");
    rd_exp(A_CLO, 500, "R10 tick landed on clear edge");

    // R8 watchdog disarmed, then armed
    wr(A_DV, 1000);
    wr(A_ST, 32'h3F);
    wr(A_WD, 0);
    wr(a_m(5), 300);
    wr(A_CLO, 299);
    wr(A_DV, 0);
    repeat (5) @(negedge clk);
    chk(32'(wdog_rst), 0, "R8 disarmed no reset");
    rd_exp(A_ST, 32'h20, "R8 channel 5 flag set");
    wr(A_DV, 1000);
    wr(A_ST, 32'h3F);
    wr(A_WD, 1);
    wr(A_CLO, 299);
    wr(A_DV, 0);
    repeat (5) @(negedge clk);
    chk(32'(wdog_rst), 1, "R8 armed reset asserted");
    wr(A_DV, 1000);
    wr(A_ST, 32'h20);
    repeat (3) @(negedge clk);
    chk(32'(wdog_rst), 0, "R8 reset released by clear");

    repeat (5) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    finish_run();
  end
endmodule